// File: doc/BRIEF.md
# Trail Trace Identifier Receiver

This block takes a serial trail trace bit stream, one bit per accepted beat, and packs it into bytes. Each bit can be complemented, and the byte can be assembled most-significant-bit first or least-significant-bit first. The block finds the 16-byte identifier frame boundary from the start marker: the one byte of the frame with bit 7 set. After a whole aligned frame has arrived, it moves that frame into a 16-byte received-identifier buffer. It then compares the buffer with a 16-byte expected identifier that software loads.

Software reaches both buffers through byte pointers. Each pointer can be loaded directly and steps by one on every access, wrapping from 15 back to 0. The received buffer can only be read. The expected buffer can be read and written. Alignment can be turned off. In that mode every run of 16 consecutive bytes is stored, markers are ignored, and the comparison is frozen.

The serial input uses a valid/ready pair. `bit_ready` is always high, so the block never applies back-pressure. A bit is taken on every clock edge where `bit_valid` is high, and idle cycles between bits have no effect. The pointer ports are plain strobes. The read data shows the byte at the current pointer with no latency.

Top module: `ttid_rx`

## Requirements
- R1: With `cfg_align_dis`=1, `aligned` is 0, marker bits are ignored, and each group of 16 consecutive received bytes is committed in arrival order.
- R2: `mismatch` is updated only when a frame is committed while `cfg_cmp_en`=1 and `cfg_align_dis`=0. It becomes 1 if the received buffer differs from the expected buffer and 0 if they are equal. At all other times it holds its value.
- R3: With `cfg_inv_en`=1 every serial bit is complemented before it enters byte assembly. With `cfg_inv_en`=0 bits pass through unchanged.
- R4: With `cfg_lsb_first`=0 the first bit of a byte lands in bit 7. With `cfg_lsb_first`=1 it lands in bit 0.
- R5: Received-buffer address 0 holds the marker byte of the frame, and addresses 1 to 15 hold the bytes that follow it, in order.
- R6: Every access steps its pointer by one, and an access at 15 wraps the pointer to 0. A read strobe is an access on the received side. A read or write strobe is an access on the expected side.
- R7: `exp_wr` stores `exp_wdata` at `exp_ptr`. `exp_rdata` always shows the expected byte at `exp_ptr`.
- R8: After reset, `aligned`, `mismatch`, both pointers and all buffer contents are 0.
- R9: `aligned` rises when a marker byte appears at a 16-byte spacing for the third frame in a row. It falls on the first byte whose bit 7 disagrees with its frame position.
- R10: The received buffer changes only when a complete frame is committed. A read in the middle of a frame returns the previous frame's byte.
- R11: `rx_ptr_wr` or `exp_ptr_wr` loads the pointer with the 4-bit value given, and this takes priority over stepping.
- R12: `bit_ready` is always 1, and cycles with `bit_valid`=0 do not change the byte being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial trace bit |
| bit_valid | input | 1 | `bit_in` is valid this cycle |
| bit_ready | output | 1 | Always 1 |
| cfg_align_dis | input | 1 | 1 turns off frame alignment |
| cfg_cmp_en | input | 1 | 1 enables comparison with the expected identifier |
| cfg_inv_en | input | 1 | 1 complements incoming bits |
| cfg_lsb_first | input | 1 | 1 puts the first bit of a byte in bit 0 |
| rx_ptr_wr | input | 1 | Load the received pointer |
| rx_ptr_wdata | input | 4 | Value to load into the received pointer |
| rx_rd | input | 1 | Read access to the received buffer; steps the pointer |
| rx_ptr | output | 4 | Received pointer |
| rx_rdata | output | 8 | Received byte at `rx_ptr` |
| exp_ptr_wr | input | 1 | Load the expected pointer |
| exp_ptr_wdata | input | 4 | Value to load into the expected pointer |
| exp_rd | input | 1 | Read access to the expected buffer; steps the pointer |
| exp_wr | input | 1 | Write access to the expected buffer; steps the pointer |
| exp_wdata | input | 8 | Byte to write |
| exp_ptr | output | 4 | Expected pointer |
| exp_rdata | output | 8 | Expected byte at `exp_ptr` |
| mismatch | output | 1 | Result of the last active comparison |
| aligned | output | 1 | Frame alignment is held |

## Verification
The stream is sent under all four combinations of inversion and bit order, each with a different frame pattern and some with idle gaps between bits. A fault in the complement, in the byte order or in the handling of gaps therefore puts wrong bytes into the buffer. The lock sequence starts after leading non-marker bytes, so locking on the first frame or holding on to a stale position would show up. A frame with a misplaced marker separates loss-on-one-error from tolerant behaviour. A marker-free run with alignment off shows that capture no longer depends on the marker. Frames that differ from or equal the expected identifier are sent with comparison on, with comparison off and with alignment off, which separates the hold rule of the mismatch flag from its update rule.

// File: rtl/ttid_pkg.sv
package ttid_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ttid_ptr.sv
module ttid_ptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R11
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/ttid_deser.sv
module ttid_deser
  import ttid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_in,
  input  logic  bit_valid,
  input  logic  inv_en,
  input  logic  lsb_first,
  output logic  byte_vld,
  output byte_t byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] nbits;
  byte_t            shreg, shreg_nx;
  logic             b;

  always_comb begin
    b = bit_in ^ inv_en;
    shreg_nx = lsb_first ? {b, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], b};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbits    <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (bit_valid) begin
        shreg <= shreg_nx;
        nbits <= nbits + 1'b1;
        if (nbits == CNT_W'(BYTE_W - 1)) begin
          byte_vld <= 1'b1;
          byte_out <= shreg_nx;
        end
      end
    end
  end

  // R12
  byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/ttid_align.sv
module ttid_align
  import ttid_pkg::*;
#(
  parameter int ID_LEN      = 16,
  parameter int LOCK_FRAMES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_vld,
  input  byte_t                    byte_in,
  input  logic                     align_dis,
  output logic                     aligned,
  output logic                     frame_done,
  output logic [ID_LEN*BYTE_W-1:0] rx_flat
);
  localparam int PTR_W = $clog2(ID_LEN);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ID_LEN - 1);

  logic [PTR_W-1:0] pos, pos_cur;
  logic [CNT_W-1:0] hits, hits_nx;
  logic             al_nx, restart, err, marker, at_start, commit;
  byte_t            stage [ID_LEN];

  always_comb begin
    marker   = byte_in[BYTE_W-1];
    at_start = (pos == '0);
    restart  = 1'b0;
    err      = 1'b0;
    hits_nx  = hits;
    al_nx    = aligned;
    if (align_dis) begin
      al_nx   = 1'b0;
      hits_nx = '0;
    end else if (aligned) begin
      if (at_start != marker) begin
        err     = 1'b1;
        al_nx   = 1'b0;
        restart = marker;
        hits_nx = marker ? CNT_W'(1) : '0;
      end
    end else if (marker) begin
      if (at_start && hits != '0) begin
        hits_nx = hits + 1'b1;
        if (hits_nx == CNT_W'(LOCK_FRAMES)) al_nx = 1'b1;
      end else begin
        restart = 1'b1;
        hits_nx = CNT_W'(1);
      end
    end else if (at_start && hits != '0) begin
      hits_nx = '0;
    end
    pos_cur = restart ? '0 : pos;
    commit  = byte_vld && (pos_cur == LAST) && (align_dis || (aligned && !err));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos        <= '0;
      hits       <= '0;
      aligned    <= 1'b0;
      frame_done <= 1'b0;
      rx_flat    <= '0;
      for (int i = 0; i < ID_LEN; i++) stage[i] <= '0;
    end else begin
      frame_done <= commit;
      if (byte_vld) begin
        pos            <= pos_cur + 1'b1;
        hits           <= hits_nx;
        aligned        <= al_nx;
        stage[pos_cur] <= byte_in;
      end else begin
        aligned <= aligned && !align_dis;
      end
      if (commit) begin
        for (int i = 0; i < ID_LEN - 1; i++) rx_flat[i*BYTE_W +: BYTE_W] <= stage[i];
        rx_flat[(ID_LEN-1)*BYTE_W +: BYTE_W] <= byte_in;
      end
    end
  end

  // R9
  align_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(byte_vld && byte_in[BYTE_W-1] && !align_dis));
  // R1
  align_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_dis |=> !aligned);
  // R10
  buf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_flat) |-> frame_done);
endmodule

// File: rtl/ttid_rx.sv
module ttid_rx
  import ttid_pkg::*;
#(
  parameter int ID_LEN      = 16,
  parameter int LOCK_FRAMES = 3,
  localparam int PTR_W      = $clog2(ID_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             cfg_align_dis,
  input  logic             cfg_cmp_en,
  input  logic             cfg_inv_en,
  input  logic             cfg_lsb_first,
  input  logic             rx_ptr_wr,
  input  logic [PTR_W-1:0] rx_ptr_wdata,
  input  logic             rx_rd,
  output logic [PTR_W-1:0] rx_ptr,
  output logic [7:0]       rx_rdata,
  input  logic             exp_ptr_wr,
  input  logic [PTR_W-1:0] exp_ptr_wdata,
  input  logic             exp_rd,
  input  logic             exp_wr,
  input  logic [7:0]       exp_wdata,
  output logic [PTR_W-1:0] exp_ptr,
  output logic [7:0]       exp_rdata,
  output logic             mismatch,
  output logic             aligned
);
  logic                     byte_vld, frame_done;
  byte_t                    byte_asm;
  logic [ID_LEN*BYTE_W-1:0] rx_flat, exp_flat;
  byte_t                    exp_mem [ID_LEN];

  assign bit_ready = 1'b1;

  ttid_deser u_deser (
    .clk, .rst_n, .bit_in, .bit_valid,
    .inv_en(cfg_inv_en), .lsb_first(cfg_lsb_first),
    .byte_vld, .byte_out(byte_asm)
  );

  ttid_align #(.ID_LEN(ID_LEN), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk, .rst_n, .byte_vld, .byte_in(byte_asm), .align_dis(cfg_align_dis),
    .aligned, .frame_done, .rx_flat
  );

  ttid_ptr #(.PTR_W(PTR_W)) u_rx_ptr (
    .clk, .rst_n, .load(rx_ptr_wr), .load_val(rx_ptr_wdata), .step(rx_rd), .ptr(rx_ptr)
  );

  ttid_ptr #(.PTR_W(PTR_W)) u_exp_ptr (
    .clk, .rst_n, .load(exp_ptr_wr), .load_val(exp_ptr_wdata),
    .step(exp_rd | exp_wr), .ptr(exp_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ID_LEN; i++) exp_mem[i] <= '0;
    end else if (exp_wr) begin
      exp_mem[exp_ptr] <= exp_wdata;
    end
  end

  for (genvar g = 0; g < ID_LEN; g++) begin : g_flat
    assign exp_flat[g*BYTE_W +: BYTE_W] = exp_mem[g];
  end

  assign rx_rdata  = rx_flat[rx_ptr*BYTE_W +: BYTE_W];
  assign exp_rdata = exp_mem[exp_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n)
      mismatch <= 1'b0;
    else if (frame_done && cfg_cmp_en && !cfg_align_dis)
      mismatch <= (rx_flat != exp_flat);
  end

  // R2
  mis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && cfg_cmp_en && !cfg_align_dis) |=> $stable(mismatch));
endmodule

// File: tb/ttid_rx_bench.sv
module ttid_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 0, bit_valid = 0, bit_ready;
  logic cfg_align_dis = 0, cfg_cmp_en = 0, cfg_inv_en = 0, cfg_lsb_first = 0;
  logic rx_ptr_wr = 0, rx_rd = 0, exp_ptr_wr = 0, exp_rd = 0, exp_wr = 0;
  logic [3:0] rx_ptr_wdata = 0, exp_ptr_wdata = 0, rx_ptr, exp_ptr;
  logic [7:0] exp_wdata = 0, rx_rdata, exp_rdata;
  logic mismatch, aligned;
  int checks = 0, failures = 0;
  logic [7:0] fr [16];
  logic [7:0] ev [16];

  always #2 clk = ~clk;

  ttid_rx u_ttid_rx (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit gap);
    for (int i = 0; i < 8; i++) begin
      bit_in = v[cfg_lsb_first ? i : 7 - i] ^ cfg_inv_en;
      bit_valid = 1'b1;
      @(negedge clk);
      if (gap) begin
        bit_valid = 1'b0;
        bit_in = ~bit_in;
        @(negedge clk);
      end
    end
    bit_valid = 1'b0;
  endtask

  task automatic send_frame(input bit gap);
    for (int i = 0; i < 16; i++) send_byte(fr[i], gap);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_rx_all(input string req);
    for (int i = 0; i < 16; i++) begin
      chk(req, rx_rdata, fr[i]);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    end
  endtask

  task automatic set_e();
    for (int i = 0; i < 16; i++) fr[i] = ev[i];
  endtask

  task automatic set_p(input int k);
    for (int i = 0; i < 16; i++)
      fr[i] = (i == 0) ? (8'h80 | 8'(k * 11 + 3)) : (8'(i * 37 + k * 11) & 8'h7F);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ev[i] = (i == 0) ? 8'hC1 : 8'(8'h41 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 aligned", aligned, 0);
    chk("R8 mismatch", mismatch, 0);
    chk("R8 ptrs", {rx_ptr, exp_ptr}, 0);
    chk("R8 rx byte", rx_rdata, 0);
    chk("R12 ready", bit_ready, 1);
    // R7 expected buffer write, R6 wrap
    for (int i = 0; i < 16; i++) begin
      exp_wdata = ev[i]; exp_wr = 1'b1; @(negedge clk);
    end
    exp_wr = 1'b0;
    chk("R6 exp wrap", exp_ptr, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R7 exp read", exp_rdata, ev[i]);
      exp_rd = 1'b1; @(negedge clk); exp_rd = 1'b0;
    end
    // R9 lock after three frames, junk first
    cfg_cmp_en = 1'b1;
    send_byte(8'h12, 0); send_byte(8'h34, 0);
    set_e();
    send_frame(0); chk("R9 no lock f1", aligned, 0);
    send_frame(0); chk("R9 no lock f2", aligned, 0);
    send_frame(0); chk("R9 lock f3", aligned, 1);
    read_rx_all("R5 rx buffer");
    chk("R6 rx wrap", rx_ptr, 0);
    chk("R2 equal", mismatch, 0);
    // R3 R4 R12 sweep of inversion and order
    for (int k = 0; k < 4; k++) begin
      logic [7:0] prev0;
      prev0 = fr[0];
      cfg_inv_en = k[0]; cfg_lsb_first = k[1];
      set_p(k);
      for (int i = 0; i < 8; i++) send_byte(fr[i], k[0]);
      chk("R10 mid frame", rx_rdata, prev0);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      rx_ptr_wdata = 4'd0; rx_ptr_wr = 1'b1; @(negedge clk); rx_ptr_wr = 1'b0;
      chk("R11 rx load", rx_ptr, 0);
      for (int i = 8; i < 16; i++) send_byte(fr[i], k[0]);
      repeat (4) @(negedge clk);
      read_rx_all(k[0] ? "R3 inv" : "R4 order");
      chk("R2 differ", mismatch, 1);
      chk("R9 held", aligned, 1);
    end
    cfg_inv_en = 0; cfg_lsb_first = 0;
    set_e(); send_frame(0);
    chk("R2 back equal", mismatch, 0);
    // R2 hold while compare off
    cfg_cmp_en = 1'b0;
    set_p(0); send_frame(0);
    chk("R2 hold off", mismatch, 0);
    read_rx_all("R10 capture cmp off");
    // R1 alignment disabled
    cfg_cmp_en = 1'b1; cfg_align_dis = 1'b1;
    @(negedge clk);
    chk("R1 aligned low", aligned, 0);
    for (int i = 0; i < 16; i++) fr[i] = 8'(i * 5 + 1);
    send_frame(0);
    read_rx_all("R1 no marker");
    chk("R2 hold align off", mismatch, 0);
    // R9 relock then loss on one error
    cfg_align_dis = 1'b0;
    set_e();
    send_frame(0); send_frame(0); send_frame(0);
    chk("R9 relock", aligned, 1);
    fr[5] = fr[5] | 8'h80;
    send_frame(0);
    chk("R9 loss", aligned, 0);
    // R11 pointer loads
    set_e();
    rx_ptr_wdata = 4'd5; rx_ptr_wr = 1'b1; @(negedge clk); rx_ptr_wr = 1'b0;
    chk("R11 rx byte5", rx_rdata, ev[5]);
    exp_ptr_wdata = 4'hF; exp_ptr_wr = 1'b1; @(negedge clk); exp_ptr_wr = 1'b0;
    exp_wdata = 8'h5A; exp_wr = 1'b1; @(negedge clk); exp_wr = 1'b0;
    chk("R6 exp wrap write", exp_ptr, 0);
    exp_ptr_wr = 1'b1; @(negedge clk); exp_ptr_wr = 1'b0;
    chk("R7 exp byte15", exp_rdata, 8'h5A);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule